// File: doc/BRIEF.md
# Split Issue Queue with Per-Thread Half Steering

This block holds decoded instructions until their operands are ready and then releases them to execution. It is built from two identical halves, each with its own storage, its own wakeup logic, its own oldest-first picker and its own private issue port. An upstream dispatch stage offers at most one instruction per cycle. Each instruction carries a thread number, two source tags with ready flags, and an opaque payload. The steering logic decides which half receives the instruction, based on the current threading mode.

With a single thread, instructions are spread over both halves so that the whole queue is usable. With two, four or eight threads, every thread is tied to one half. A thread that floods its half therefore cannot starve the threads that live in the other half. A result-tag broadcast bus marks waiting sources as ready. Each half reports when it is completely occupied.

Top module: `iq_dual_half`

## Requirements
- R1: The queue has two halves of ENTRIES slots each (32 by default). `half_full_o[h]` is 1 exactly when every slot of half h holds an instruction.
- R2: Instructions placed in half 0 leave only through issue port 0, and instructions placed in half 1 leave only through issue port 1.
- R3: In single-thread mode (`mode_i` = 0) the thread number is ignored. The preferred half is half 0 after reset, and after each accepted dispatch the next preferred half is the opposite of the half just used.
- R4: In single-thread mode, if the preferred half is full the instruction goes to the other half. `disp_stall_o` rises only when both halves are full.
- R5: In the multithread modes (`mode_i` = 1, 2, 3 for two, four and eight threads), thread t is placed in half (t mod 2), which is bit 0 of the thread number.
- R6: In the multithread modes a dispatch stalls only when the half of its own thread is full. Threads mapped to the other half keep dispatching.
- R7: An entry can issue only when both of its sources are ready. A source is ready when its flag was set at dispatch, or when a wakeup broadcast carrying a matching tag arrives in the dispatch cycle or any later cycle.
- R8: Each half issues at most one entry per cycle. It picks the eligible entry that was dispatched earliest, whatever slot that entry occupies, and it frees that slot at the clock edge that ends the issue cycle. An entry whose last source becomes ready at an edge shows up on its issue port right after that edge.
- R9: After reset both halves are empty, no port issues, nothing stalls, and the single-thread preference points at half 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Threading mode: 0 single, 1 two-way, 2 four-way, 3 eight-way |
| disp_vld_i | input | 1 | Dispatch offer valid |
| disp_tid_i | input | TID_W | Thread number of the offered instruction |
| disp_src0_tag_i | input | TAG_W | First source tag |
| disp_src0_rdy_i | input | 1 | First source already ready |
| disp_src1_tag_i | input | TAG_W | Second source tag |
| disp_src1_rdy_i | input | 1 | Second source already ready |
| disp_payload_i | input | PAY_W | Opaque instruction payload |
| disp_stall_o | output | 1 | Offer not accepted this cycle |
| wake_vld_i | input | 1 | Wakeup broadcast valid |
| wake_tag_i | input | TAG_W | Tag being marked ready |
| half_full_o | output | 2 | Per-half full flags |
| iss_vld_o | output | 2 | Per-port issue valid |
| iss_tid_o | output | 2 x TID_W | Thread number of the issuing entry, per port |
| iss_payload_o | output | 2 x PAY_W | Payload of the issuing entry, per port |

## Verification
The hardest situation to reach is an age order that differs from slot order. It is set up by waking a middle entry so that it drains, leaving an idle cycle, and then dispatching into the freed low slot. A single broadcast then makes three entries eligible at once, and they must leave in dispatch order. The single-thread fallback needs one half full while the other is not, and the stall case needs both halves full. The bench reaches these by filling the halves in two-way mode with entries that wait on a tag nobody broadcasts, then switching modes before draining each half with one wakeup.

// File: rtl/iq_pkg.sv
`timescale 1ns/1ps
package iq_pkg;
   typedef enum logic [1:0] {
      MODE_ST   = 2'd0,
      MODE_SMT2 = 2'd1,
      MODE_SMT4 = 2'd2,
      MODE_SMT8 = 2'd3
   } thr_mode_e;
endpackage

// File: rtl/iq_steer.sv
`timescale 1ns/1ps
module iq_steer
   import iq_pkg::*;
#(
   parameter int TID_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       mode_i,
   input  logic             disp_vld_i,
   input  logic [TID_W-1:0] disp_tid_i,
   input  logic [1:0]       full_i,
   output logic [1:0]       alloc_o,
   output logic             stall_o
);
   logic pref_q;
   logic tgt;
   logic blocked;
   logic single;

   assign single = (thr_mode_e'(mode_i) == MODE_ST);

   always_comb begin
      if (single) begin
         tgt     = full_i[pref_q] ? ~pref_q : pref_q;
         blocked = &full_i;
      end else begin
         tgt     = disp_tid_i[0];
         blocked = full_i[disp_tid_i[0]];
      end
      stall_o = disp_vld_i & blocked;
      alloc_o = (disp_vld_i && !blocked) ? (2'b01 << tgt) : 2'b00;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         pref_q <= 1'b0;
      else if (single && disp_vld_i && !blocked)
         pref_q <= ~tgt;
   end

   // R4: with room in either half a single-thread offer is never held back
   a_r4_st_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_vld_i && mode_i == 2'd0 && !(&full_i)) |-> !stall_o);
   // R5: multithread placement follows thread bit 0
   a_r5_thread_lock: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i != 2'd0 && alloc_o != 2'b00) |-> alloc_o[disp_tid_i[0]]);
   a_r2_one_half: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(alloc_o));
endmodule

// File: rtl/iq_half.sv
`timescale 1ns/1ps
module iq_half #(
   parameter int ENTRIES = 32,
   parameter int TAG_W   = 6,
   parameter int TID_W   = 3,
   parameter int PAY_W   = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc_i,
   input  logic [TID_W-1:0] in_tid_i,
   input  logic [TAG_W-1:0] in_s0_tag_i,
   input  logic             in_s0_rdy_i,
   input  logic [TAG_W-1:0] in_s1_tag_i,
   input  logic             in_s1_rdy_i,
   input  logic [PAY_W-1:0] in_payload_i,
   input  logic             wake_vld_i,
   input  logic [TAG_W-1:0] wake_tag_i,
   output logic             full_o,
   output logic             iss_vld_o,
   output logic [TID_W-1:0] iss_tid_o,
   output logic [PAY_W-1:0] iss_payload_o
);
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   generate
      if (ENTRIES < 2) begin : g_bad_depth
         $error("iq_half: ENTRIES must be at least 2");
      end
   endgenerate

   logic [ENTRIES-1:0] ent_vld;
   logic [ENTRIES-1:0] rdy0;
   logic [ENTRIES-1:0] rdy1;
   logic [ENTRIES-1:0] elig;
   logic [ENTRIES-1:0] grant;
   logic [TAG_W-1:0]   tag0  [ENTRIES];
   logic [TAG_W-1:0]   tag1  [ENTRIES];
   logic [TID_W-1:0]   tids  [ENTRIES];
   logic [PAY_W-1:0]   pays  [ENTRIES];
   // older[i][j] set: entry j was dispatched before entry i
   logic [ENTRIES-1:0] older [ENTRIES];
   logic [IDX_W-1:0]   free_idx;
   logic [IDX_W-1:0]   iss_idx;
   logic               new_r0;
   logic               new_r1;

   assign full_o = &ent_vld;
   assign elig   = ent_vld & rdy0 & rdy1;
   assign new_r0 = in_s0_rdy_i | (wake_vld_i && wake_tag_i == in_s0_tag_i);
   assign new_r1 = in_s1_rdy_i | (wake_vld_i && wake_tag_i == in_s1_tag_i);

   always_comb begin
      free_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--)
         if (!ent_vld[i]) free_idx = IDX_W'(i);
   end

   always_comb begin
      for (int i = 0; i < ENTRIES; i++)
         grant[i] = elig[i] && !(|(elig & older[i]));
   end

   always_comb begin
      iss_idx = '0;
      for (int i = 0; i < ENTRIES; i++)
         if (grant[i]) iss_idx = IDX_W'(i);
      iss_vld_o     = |grant;
      iss_tid_o     = tids[iss_idx];
      iss_payload_o = pays[iss_idx];
   end

   generate
      for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
         logic take;
         assign take = alloc_i && (free_idx == IDX_W'(g));

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ent_vld[g] <= 1'b0;
               rdy0[g]    <= 1'b0;
               rdy1[g]    <= 1'b0;
               tag0[g]    <= '0;
               tag1[g]    <= '0;
               tids[g]    <= '0;
               pays[g]    <= '0;
            end else if (take) begin
               ent_vld[g] <= 1'b1;
               rdy0[g]    <= new_r0;
               rdy1[g]    <= new_r1;
               tag0[g]    <= in_s0_tag_i;
               tag1[g]    <= in_s1_tag_i;
               tids[g]    <= in_tid_i;
               pays[g]    <= in_payload_i;
            end else begin
               if (grant[g]) ent_vld[g] <= 1'b0;
               if (wake_vld_i && wake_tag_i == tag0[g]) rdy0[g] <= 1'b1;
               if (wake_vld_i && wake_tag_i == tag1[g]) rdy1[g] <= 1'b1;
            end
         end

         always_ff @(posedge clk) begin
            if (!rst_n)
               older[g] <= '0;
            else if (take)
               older[g] <= ent_vld & ~grant;
            else if (alloc_i)
               older[g][free_idx] <= 1'b0;
         end
      end
   endgenerate

   // R1: the steering never places into a half that is full
   a_r1_no_alloc_full: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_i |-> !full_o);
   // R8: at most one winner per half per cycle
   a_r8_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   // R8: the issued slot is empty afterwards
   a_r8_issue_frees: assert property (@(posedge clk) disable iff (!rst_n)
      iss_vld_o |=> !ent_vld[$past(iss_idx)]);
endmodule

// File: rtl/iq_dual_half.sv
`timescale 1ns/1ps
module iq_dual_half #(
   parameter int ENTRIES = 32,
   parameter int TAG_W   = 6,
   parameter int TID_W   = 3,
   parameter int PAY_W   = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [1:0]            mode_i,
   input  logic                  disp_vld_i,
   input  logic [TID_W-1:0]      disp_tid_i,
   input  logic [TAG_W-1:0]      disp_src0_tag_i,
   input  logic                  disp_src0_rdy_i,
   input  logic [TAG_W-1:0]      disp_src1_tag_i,
   input  logic                  disp_src1_rdy_i,
   input  logic [PAY_W-1:0]      disp_payload_i,
   output logic                  disp_stall_o,
   input  logic                  wake_vld_i,
   input  logic [TAG_W-1:0]      wake_tag_i,
   output logic [1:0]            half_full_o,
   output logic [1:0]            iss_vld_o,
   output logic [1:0][TID_W-1:0] iss_tid_o,
   output logic [1:0][PAY_W-1:0] iss_payload_o
);
   localparam int HALVES = 2;

   generate
      if (TID_W < 3) begin : g_bad_tid
         $error("iq_dual_half: TID_W must cover eight threads");
      end
   endgenerate

   logic [HALVES-1:0] alloc;

   iq_steer #(.TID_W(TID_W)) u_steer (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_i     (mode_i),
      .disp_vld_i (disp_vld_i),
      .disp_tid_i (disp_tid_i),
      .full_i     (half_full_o),
      .alloc_o    (alloc),
      .stall_o    (disp_stall_o)
   );

   generate
      for (genvar h = 0; h < HALVES; h++) begin : g_half
         iq_half #(
            .ENTRIES (ENTRIES),
            .TAG_W   (TAG_W),
            .TID_W   (TID_W),
            .PAY_W   (PAY_W)
         ) u_half (
            .clk           (clk),
            .rst_n         (rst_n),
            .alloc_i       (alloc[h]),
            .in_tid_i      (disp_tid_i),
            .in_s0_tag_i   (disp_src0_tag_i),
            .in_s0_rdy_i   (disp_src0_rdy_i),
            .in_s1_tag_i   (disp_src1_tag_i),
            .in_s1_rdy_i   (disp_src1_rdy_i),
            .in_payload_i  (disp_payload_i),
            .wake_vld_i    (wake_vld_i),
            .wake_tag_i    (wake_tag_i),
            .full_o        (half_full_o[h]),
            .iss_vld_o     (iss_vld_o[h]),
            .iss_tid_o     (iss_tid_o[h]),
            .iss_payload_o (iss_payload_o[h])
         );
      end
   endgenerate

   // R6: in multithread modes a stall implies the thread's own half is full
   a_r6_stall_own_half: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_stall_o && mode_i != 2'd0) |-> half_full_o[disp_tid_i[0]]);
endmodule

// File: tb/sim_iq_dual_half.sv
`timescale 1ns/1ps
module sim_iq_dual_half;
   localparam int N = 32;
   localparam int TAG_W = 6;
   localparam int TID_W = 3;
   localparam int PAY_W = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] mode = 2'd0;
   logic disp_vld = 1'b0;
   logic [TID_W-1:0] disp_tid = '0;
   logic [TAG_W-1:0] t0 = '0, t1 = '0;
   logic r0 = 1'b0, r1 = 1'b0;
   logic [PAY_W-1:0] pay = '0;
   logic stall;
   logic wake_vld = 1'b0;
   logic [TAG_W-1:0] wake_tag = '0;
   logic [1:0] full;
   logic [1:0] iss_vld;
   logic [1:0][TID_W-1:0] iss_tid;
   logic [1:0][PAY_W-1:0] iss_pay;

   int checks = 0;
   int fails = 0;
   logic seen_stall;

   always #2.5 clk = ~clk;

   iq_dual_half #(.ENTRIES(N), .TAG_W(TAG_W), .TID_W(TID_W), .PAY_W(PAY_W)) u0 (
      .clk(clk), .rst_n(rst_n), .mode_i(mode),
      .disp_vld_i(disp_vld), .disp_tid_i(disp_tid),
      .disp_src0_tag_i(t0), .disp_src0_rdy_i(r0),
      .disp_src1_tag_i(t1), .disp_src1_rdy_i(r1),
      .disp_payload_i(pay), .disp_stall_o(stall),
      .wake_vld_i(wake_vld), .wake_tag_i(wake_tag),
      .half_full_o(full), .iss_vld_o(iss_vld),
      .iss_tid_o(iss_tid), .iss_payload_o(iss_pay));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // one dispatch cycle; called and returns at a falling edge
   task automatic put(input int tid, input int a, input bit ar, input int b, input bit br,
                      input int p);
      disp_vld = 1'b1; disp_tid = TID_W'(tid);
      t0 = TAG_W'(a); r0 = ar; t1 = TAG_W'(b); r1 = br; pay = PAY_W'(p);
      #1 seen_stall = stall;
      @(negedge clk);
      disp_vld = 1'b0;
   endtask

   task automatic wake(input int tag);
      wake_vld = 1'b1; wake_tag = TAG_W'(tag);
      @(negedge clk);
      wake_vld = 1'b0;
   endtask

   task automatic idle();
      @(negedge clk);
   endtask

   task automatic expect_issue(input int port, input int p, input string req);
      chk(iss_vld[port] == 1'b1 && iss_vld[1-port] == 1'b0, req, iss_vld, 1 << port);
      chk(iss_pay[port] == PAY_W'(p), req, iss_pay[port], p);
   endtask

   task automatic t_reset();
      chk(iss_vld == 2'b00, "R9", iss_vld, 0);
      chk(full == 2'b00, "R9", full, 0);
      chk(stall == 1'b0, "R9", stall, 0);
   endtask

   task automatic t_single_alternate();
      mode = 2'd0;
      put(1, 0, 1, 0, 1, 16'h100);
      expect_issue(0, 16'h100, "R3");
      idle();
      chk(iss_vld == 2'b00, "R8", iss_vld, 0);
      put(0, 0, 1, 0, 1, 16'h101);
      expect_issue(1, 16'h101, "R3");
      idle();
      put(7, 0, 1, 0, 1, 16'h102);
      expect_issue(0, 16'h102, "R3");
      idle();
   endtask

   task automatic t_thread_map();
      mode = 2'd1;
      put(0, 0, 1, 0, 1, 16'h110); expect_issue(0, 16'h110, "R5"); idle();
      put(1, 0, 1, 0, 1, 16'h111); expect_issue(1, 16'h111, "R5");
      chk(iss_tid[1] == 3'd1, "R2", iss_tid[1], 1); idle();
      mode = 2'd2;
      put(3, 0, 1, 0, 1, 16'h112); expect_issue(1, 16'h112, "R5"); idle();
      put(2, 0, 1, 0, 1, 16'h113); expect_issue(0, 16'h113, "R5"); idle();
      mode = 2'd3;
      put(6, 0, 1, 0, 1, 16'h114); expect_issue(0, 16'h114, "R5"); idle();
      put(7, 0, 1, 0, 1, 16'h115); expect_issue(1, 16'h115, "R5"); idle();
   endtask

   task automatic t_wakeup();
      mode = 2'd1;
      put(0, 5, 0, 6, 0, 16'h200);
      chk(iss_vld == 2'b00, "R7", iss_vld, 0);
      wake(5);
      chk(iss_vld == 2'b00, "R7", iss_vld, 0);
      wake(6);
      expect_issue(0, 16'h200, "R7");
      idle();
      // broadcast in the same cycle as dispatch
      wake_vld = 1'b1; wake_tag = 6'd11;
      put(1, 11, 0, 0, 1, 16'h201);
      wake_vld = 1'b0;
      expect_issue(1, 16'h201, "R7");
      idle();
      chk(iss_vld == 2'b00, "R8", iss_vld, 0);
   endtask

   task automatic t_age();
      mode = 2'd1;
      put(0, 7, 0, 0, 1, 16'h301);
      put(0, 8, 0, 0, 1, 16'h302);
      put(0, 7, 0, 0, 1, 16'h303);
      wake(8);
      expect_issue(0, 16'h302, "R8");
      idle();
      put(0, 7, 0, 0, 1, 16'h304);   // lands in the freed lower slot
      chk(iss_vld == 2'b00, "R7", iss_vld, 0);
      wake(7);
      expect_issue(0, 16'h301, "R8"); idle();
      expect_issue(0, 16'h303, "R8"); idle();
      expect_issue(0, 16'h304, "R8"); idle();
      chk(iss_vld == 2'b00, "R8", iss_vld, 0);
   endtask

   task automatic t_full();
      int cnt;
      int bad;
      mode = 2'd1;
      for (int i = 0; i < N; i++) put(0, 9, 0, 0, 1, 16'h400 + i);
      chk(full == 2'b01, "R1", full, 1);
      put(0, 0, 1, 0, 1, 16'h4ff);
      chk(seen_stall == 1'b1, "R6", seen_stall, 1);
      chk(iss_vld == 2'b00, "R6", iss_vld, 0);
      put(1, 0, 1, 0, 1, 16'h500);
      chk(seen_stall == 1'b0, "R6", seen_stall, 0);
      expect_issue(1, 16'h500, "R6");
      idle();
      // single thread with half 0 full: preference is half 1 now, then half 0 -> fallback
      mode = 2'd0;
      put(0, 0, 1, 0, 1, 16'h501);
      chk(seen_stall == 1'b0, "R4", seen_stall, 0);
      expect_issue(1, 16'h501, "R4"); idle();
      put(0, 0, 1, 0, 1, 16'h502);
      chk(seen_stall == 1'b0, "R4", seen_stall, 0);
      expect_issue(1, 16'h502, "R4"); idle();
      mode = 2'd1;
      for (int i = 0; i < N; i++) put(1, 10, 0, 0, 1, 16'h600 + i);
      chk(full == 2'b11, "R1", full, 3);
      mode = 2'd0;
      put(0, 0, 1, 0, 1, 16'h5ff);
      chk(seen_stall == 1'b1, "R4", seen_stall, 1);
      chk(iss_vld == 2'b00, "R4", iss_vld, 0);
      wake(9);
      bad = 0; cnt = 0;
      for (int i = 0; i < N; i++) begin
         if (iss_vld != 2'b01 || iss_pay[0] != PAY_W'(16'h400 + i)) bad++;
         else cnt++;
         if (i == 1) chk(full == 2'b10, "R1", full, 2);
         idle();
      end
      chk(bad == 0, "R8", cnt, N);
      wake(10);
      bad = 0; cnt = 0;
      for (int i = 0; i < N; i++) begin
         if (iss_vld != 2'b10 || iss_pay[1] != PAY_W'(16'h600 + i)) bad++;
         else cnt++;
         idle();
      end
      chk(bad == 0, "R2", cnt, N);
      chk(iss_vld == 2'b00 && full == 2'b00, "R1", {iss_vld, full}, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single_alternate();
      t_thread_map();
      t_wakeup();
      t_age();
      t_full();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule